// File: doc/BRIEF.md
# Last-Level Cache Shared-Modified Load Tagger

This block is the coherence bookkeeping of a shared last-level cache. For every line it tracks a coherence state, the thread that last wrote it, and a bit vector of the threads that hold a copy. Private first-level caches send it their load misses and their stores, each tagged with a thread number. Every load gets a response. The response carries one extra flag. The flag is set when a different thread left the line modified before this load arrived. A race detector downstream uses the flag to keep loads that may race and to drop loads that cannot.

On a store, the block sends invalidations to every other thread that holds the line. It sends them one thread per cycle, lowest thread number first. It then marks the line modified and records the storing thread as its writer. While invalidations are still being sent, the block refuses new requests.

The tag and state store is a small direct-mapped table. Any miss allocates the indexed entry and overwrites the previous tag. The entry's writer and sharer history are lost with it.

Top module: `smtag_top`

## Requirements
- R1: A load that misses the table gets a response with the shared-modified flag at 0. Every accepted load gets exactly one response, with `rsp_valid` high in the cycle after the accepting edge. The response carries the load's thread and address.
- R2: A load that hits a line in the modified state gets the flag at 1 when the line's recorded writer is not the requesting thread. The state checked is the one held before the load is serviced.
- R3: A load that hits a line in the shared state gets the flag at 0. So does a load that hits a line the requesting thread itself modified.
- R4: After a load is serviced, the line is shared and the requester is added to its sharers. A second load from yet another thread therefore gets the flag at 0.
- R5: A store that hits sends one invalidation per cycle, in ascending thread order. It sends one to every sharer except the storing thread. `inv_addr` holds the store address for the whole burst. No invalidation is sent without a store that calls for it.
- R6: After a store, the line is modified, its writer is the storing thread, and that thread is its only sharer. The storing thread never receives an invalidation for its own store.
- R7: `req_ready` is low in every cycle in which an invalidation is being presented. No request is accepted until the last invalidation of a burst has been sent.
- R8: A store that misses sends no invalidations. It allocates the line as modified by the storing thread, so a later load from another thread gets the flag at 1.
- R9: An access to the same table index with a different tag evicts the old line. A later access to the old address misses: loads get the flag at 0, and earlier sharers are not invalidated.
- R10: After reset, no response and no invalidation is presented, `req_ready` is high, and every table entry is invalid.
- R11: A store produces no load response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load miss from a first-level cache |
| req_tid | input | TID_W | Requesting thread |
| req_addr | input | ADDR_W | Line address (low IDX_W bits index the table) |
| rsp_valid | output | 1 | Load response present (one cycle) |
| rsp_smod | output | 1 | Shared-modified flag of the response |
| rsp_tid | output | TID_W | Thread the response belongs to |
| rsp_addr | output | ADDR_W | Address of the answered load |
| inv_valid | output | 1 | Invalidation present this cycle |
| inv_tid | output | TID_W | Thread to invalidate |
| inv_addr | output | ADDR_W | Address to invalidate |

## Verification
The hardest case to reach is a loss of coherence history through eviction. That requires two different tags to collide on one index, so that a line that was modified, or had sharers, is overwritten. A later store must then show that the old sharers are no longer invalidated. The stimulus gets there with a short chain of requests. It first builds a modified line with a known sharer set. It then reaches the same index through a second address whose upper bits differ. Finally, it returns to the first address with a load and then a store. A scoreboard predicts each response flag and each invalidation, in order.

// File: rtl/smtag_pkg.sv
package smtag_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_MOD = 2'd2
   } line_st_e;
endpackage

// File: rtl/smtag_lowbit.sv
// Finds the lowest set bit of a vector: one-hot form and index.
module smtag_lowbit #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic [N-1:0]  first_oh,
   output logic [IW-1:0] first_idx,
   output logic          any
);
   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_bit
         if (gi == 0) begin : g_lsb
            assign first_oh[gi] = vec[gi];
         end else begin : g_upper
            assign first_oh[gi] = vec[gi] & ~(|vec[gi-1:0]);
         end
      end
   endgenerate

   always_comb begin
      first_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) first_idx = IW'(i);
      end
   end

   assign any = |vec;
endmodule

// File: rtl/smtag_dir.sv
// Direct-mapped tag/state/writer/sharer table, one write port.
module smtag_dir
   import smtag_pkg::*;
#(
   parameter int IDX_W   = 3,
   parameter int TAG_W   = 9,
   parameter int NTHREAD = 4,
   parameter int TID_W   = 2,
   localparam int NSETS  = 1 << IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   rd_idx,
   input  logic [TAG_W-1:0]   rd_tag,
   output logic               rd_hit,
   output line_st_e           rd_st,
   output logic [TID_W-1:0]   rd_writer,
   output logic [NTHREAD-1:0] rd_shr,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [TAG_W-1:0]   wr_tag,
   input  line_st_e           wr_st,
   input  logic [TID_W-1:0]   wr_writer,
   input  logic [NTHREAD-1:0] wr_shr
);
   typedef struct packed {
      line_st_e           st;
      logic [TAG_W-1:0]   tag;
      logic [TID_W-1:0]   writer;
      logic [NTHREAD-1:0] shr;
   } entry_t;

   entry_t ent_rd [NSETS];
   entry_t sel;

   genvar ge;
   generate
      for (ge = 0; ge < NSETS; ge++) begin : g_ent
         entry_t ent_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ent_q <= '{st: LS_INV, tag: '0, writer: '0, shr: '0};
            end else if (wr_en && (wr_idx == IDX_W'(ge))) begin
               ent_q <= '{st: wr_st, tag: wr_tag, writer: wr_writer, shr: wr_shr};
            end
         end
         assign ent_rd[ge] = ent_q;
      end
   endgenerate

   assign sel       = ent_rd[rd_idx];
   assign rd_hit    = (sel.st != LS_INV) && (sel.tag == rd_tag);
   assign rd_st     = sel.st;
   assign rd_writer = sel.writer;
   assign rd_shr    = sel.shr;
endmodule

// File: rtl/smtag_invseq.sv
// Sends a mask of invalidations one thread per cycle, lowest first.
module smtag_invseq #(
   parameter int NTHREAD = 4,
   parameter int TID_W   = 2,
   parameter int ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [NTHREAD-1:0] start_mask,
   input  logic [ADDR_W-1:0]  start_addr,
   output logic               busy,
   output logic               inv_valid,
   output logic [TID_W-1:0]   inv_tid,
   output logic [ADDR_W-1:0]  inv_addr
);
   logic [NTHREAD-1:0] pend_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [NTHREAD-1:0] first_oh;
   logic [TID_W-1:0]   first_idx;
   logic               any;

   smtag_lowbit #(.N(NTHREAD)) u_low (
      .vec       (pend_q),
      .first_oh  (first_oh),
      .first_idx (first_idx),
      .any       (any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         addr_q <= '0;
      end else if (start) begin
         pend_q <= start_mask;
         addr_q <= start_addr;
      end else begin
         pend_q <= pend_q & ~first_oh;
      end
   end

   assign busy      = any;
   assign inv_valid = any;
   assign inv_tid   = first_idx;
   assign inv_addr  = addr_q;
endmodule

// File: rtl/smtag_top.sv
module smtag_top
   import smtag_pkg::*;
#(
   parameter int NTHREAD = 4,
   parameter int ADDR_W  = 12,
   parameter int IDX_W   = 3,
   localparam int TID_W  = $clog2(NTHREAD),
   localparam int TAG_W  = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_store,
   input  logic [TID_W-1:0]  req_tid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_smod,
   output logic [TID_W-1:0]  rsp_tid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              inv_valid,
   output logic [TID_W-1:0]  inv_tid,
   output logic [ADDR_W-1:0] inv_addr
);
   generate
      if (NTHREAD < 2 || (1 << TID_W) != NTHREAD) begin : g_bad_threads
         $error("smtag_top: NTHREAD must be a power of two, at least 2");
      end
      if (IDX_W < 1 || TAG_W < 1) begin : g_bad_split
         $error("smtag_top: ADDR_W must exceed IDX_W, IDX_W at least 1");
      end
   endgenerate

   logic [IDX_W-1:0]   idx;
   logic [TAG_W-1:0]   tag;
   logic [NTHREAD-1:0] self_oh;
   logic               accept;
   logic               inv_busy;

   logic               hit;
   line_st_e           cur_st;
   logic [TID_W-1:0]   cur_writer;
   logic [NTHREAD-1:0] cur_shr;

   line_st_e           nxt_st;
   logic [TID_W-1:0]   nxt_writer;
   logic [NTHREAD-1:0] nxt_shr;
   logic [NTHREAD-1:0] inv_mask;
   logic               smod;

   assign idx     = req_addr[IDX_W-1:0];
   assign tag     = req_addr[ADDR_W-1:IDX_W];
   assign self_oh = NTHREAD'(1) << req_tid;
   assign req_ready = ~inv_busy;
   assign accept  = req_valid & req_ready;

   smtag_dir #(
      .IDX_W   (IDX_W),
      .TAG_W   (TAG_W),
      .NTHREAD (NTHREAD),
      .TID_W   (TID_W)
   ) u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (idx),
      .rd_tag    (tag),
      .rd_hit    (hit),
      .rd_st     (cur_st),
      .rd_writer (cur_writer),
      .rd_shr    (cur_shr),
      .wr_en     (accept),
      .wr_idx    (idx),
      .wr_tag    (tag),
      .wr_st     (nxt_st),
      .wr_writer (nxt_writer),
      .wr_shr    (nxt_shr)
   );

   // Next line contents and response flag from the pre-request state.
   always_comb begin
      smod = 1'b0;
      inv_mask = '0;
      if (req_is_store) begin
         nxt_st     = LS_MOD;
         nxt_writer = req_tid;
         nxt_shr    = self_oh;
         if (hit) inv_mask = cur_shr & ~self_oh;
      end else begin
         nxt_st = LS_SHR;
         if (hit) begin
            nxt_writer = cur_writer;
            nxt_shr    = cur_shr | self_oh;
            smod       = (cur_st == LS_MOD) && (cur_writer != req_tid);
         end else begin
            nxt_writer = '0;
            nxt_shr    = self_oh;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_smod  <= 1'b0;
         rsp_tid   <= '0;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= accept & ~req_is_store;
         if (accept && !req_is_store) begin
            rsp_smod <= smod;
            rsp_tid  <= req_tid;
            rsp_addr <= req_addr;
         end
      end
   end

   smtag_invseq #(
      .NTHREAD (NTHREAD),
      .TID_W   (TID_W),
      .ADDR_W  (ADDR_W)
   ) u_inv (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept & req_is_store),
      .start_mask (inv_mask),
      .start_addr (req_addr),
      .busy       (inv_busy),
      .inv_valid  (inv_valid),
      .inv_tid    (inv_tid),
      .inv_addr   (inv_addr)
   );
endmodule

// File: rtl/smtag_chk.sv
module smtag_chk #(
   parameter int TID_W  = 2,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_is_store,
   input logic [TID_W-1:0]  req_tid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic [TID_W-1:0]  rsp_tid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic              inv_valid,
   input logic [TID_W-1:0]  inv_tid,
   input logic [ADDR_W-1:0] inv_addr
);
   logic [TID_W-1:0] st_tid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) st_tid_q <= '0;
      else if (req_valid && req_ready && req_is_store) st_tid_q <= req_tid;
   end

   // R1
   load_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_is_store) |=>
         (rsp_valid && rsp_tid == $past(req_tid) && rsp_addr == $past(req_addr)));

   // R11
   store_norsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_is_store) |=> !rsp_valid);

   // R6
   inv_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> (inv_tid != st_tid_q));

   // R5
   inv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && $past(inv_valid)) |-> (inv_tid > $past(inv_tid) && $stable(inv_addr)));

   // R7
   accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> !inv_valid);
endmodule

bind smtag_top smtag_chk #(.TID_W(TID_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_smtag_top.sv
`timescale 1ns/1ps
module tb_smtag_top;
   localparam int NTHREAD = 4;
   localparam int ADDR_W  = 12;
   localparam int IDX_W   = 3;
   localparam int TID_W   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_is_store = 1'b0;
   logic [TID_W-1:0]  req_tid = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic req_ready, rsp_valid, rsp_smod, inv_valid;
   logic [TID_W-1:0]  rsp_tid, inv_tid;
   logic [ADDR_W-1:0] rsp_addr, inv_addr;

   always #10 clk = ~clk;

   smtag_top #(.NTHREAD(NTHREAD), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_is_store(req_is_store), .req_tid(req_tid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_smod(rsp_smod), .rsp_tid(rsp_tid),
      .rsp_addr(rsp_addr), .inv_valid(inv_valid), .inv_tid(inv_tid),
      .inv_addr(inv_addr)
   );

   int n_chk = 0;
   int n_err = 0;
   int n_loads = 0;
   int n_rsp_seen = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   int    rsp_tid_q[$];
   int    rsp_addr_q[$];
   int    rsp_smod_q[$];
   string rsp_req_q[$];
   int    inv_tid_q[$];
   int    inv_addr_q[$];
   string inv_req_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send(input bit st, input int tid, input int addr);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid    = 1'b1;
      req_is_store = st;
      req_tid      = TID_W'(tid);
      req_addr     = ADDR_W'(addr);
      @(negedge clk);
      req_valid    = 1'b0;
   endtask

   task automatic do_load(input int tid, input int addr, input int smod, input string req);
      rsp_tid_q.push_back(tid);
      rsp_addr_q.push_back(addr);
      rsp_smod_q.push_back(smod);
      rsp_req_q.push_back(req);
      n_loads++;
      send(1'b0, tid, addr);
   endtask

   task automatic do_store(input int tid, input int addr, input int mask, input string req);
      for (int i = 0; i < NTHREAD; i++) begin
         if (mask[i]) begin
            inv_tid_q.push_back(i);
            inv_addr_q.push_back(addr);
            inv_req_q.push_back(req);
         end
      end
      send(1'b1, tid, addr);
   endtask

   // Monitor: pops expected items as the design presents results.
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         if (rsp_valid) begin
            n_rsp_seen++;
            if (rsp_tid_q.size() == 0) begin
               chk(1'b0, "R11", "unexpected response", 1, 0);
            end else begin
               automatic int    et = rsp_tid_q.pop_front();
               automatic int    ea = rsp_addr_q.pop_front();
               automatic int    es = rsp_smod_q.pop_front();
               automatic string rq = rsp_req_q.pop_front();
               chk(int'(rsp_tid) == et, rq, "rsp_tid", int'(rsp_tid), et);
               chk(int'(rsp_addr) == ea, rq, "rsp_addr", int'(rsp_addr), ea);
               chk(int'(rsp_smod) == es, rq, "rsp_smod", int'(rsp_smod), es);
            end
         end
         if (inv_valid) begin
            chk(req_ready == 1'b0, "R7", "req_ready during invalidation", int'(req_ready), 0);
            if (inv_tid_q.size() == 0) begin
               chk(1'b0, "R5", "unexpected invalidation", int'(inv_tid), -1);
            end else begin
               automatic int    et = inv_tid_q.pop_front();
               automatic int    ea = inv_addr_q.pop_front();
               automatic string rq = inv_req_q.pop_front();
               chk(int'(inv_tid) == et, rq, "inv_tid", int'(inv_tid), et);
               chk(int'(inv_addr) == ea, rq, "inv_addr", int'(inv_addr), ea);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   localparam int A  = 'h010; // index 0
   localparam int B  = 'h021; // index 1
   localparam int C  = 'h032; // index 2, tag 6
   localparam int C2 = 'h03A; // index 2, tag 7

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state at the ports
      chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", int'(rsp_valid), 0);
      chk(inv_valid == 1'b0, "R10", "inv_valid in reset", int'(inv_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10", "req_ready after reset", int'(req_ready), 1);
      mon_on = 1'b1;

      do_load(1, A, 0, "R1");           // empty table: miss
      do_load(2, A, 0, "R3");           // shared line
      do_load(3, A, 0, "R3");
      do_store(2, A, 'b1010, "R5");     // sharers 1,3 invalidated
      do_load(0, A, 1, "R2");           // modified by thread 2
      do_load(1, A, 0, "R4");           // now shared
      do_store(0, A, 'b0110, "R5");     // sharers 1,2
      do_store(3, A, 'b0001, "R6");     // only previous storer held it
      do_load(3, A, 0, "R3");           // own modification
      do_store(1, B, 'b0000, "R8");     // store miss
      do_load(2, B, 1, "R8");
      do_store(0, C, 'b0000, "R8");
      do_load(1, C2, 0, "R9");          // evicts C
      do_load(2, C, 0, "R9");           // history lost, evicts C2
      do_store(3, C, 'b0100, "R9");     // only thread 2 remains

      repeat (8) @(negedge clk);
      chk(rsp_tid_q.size() == 0, "R1", "responses missing", rsp_tid_q.size(), 0);
      chk(inv_tid_q.size() == 0, "R5", "invalidations missing", inv_tid_q.size(), 0);
      chk(n_rsp_seen == n_loads, "R11", "response count", n_rsp_seen, n_loads);
      chk(req_ready == 1'b1, "R7", "req_ready when idle", int'(req_ready), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule